// File: doc/BRIEF.md
# Channel-Indexed Configuration Register Bank

This block is the register bank behind the serial configuration port of a two-channel data converter. A serial front end, which is not part of this block, turns port traffic into plain register cycles: an address, write data, a write strobe and a read strobe. Read data comes back one clock later. Shared registers are reached directly. These are a control register that carries a soft-reset command, a burst-end register, an index register, and read-only identification bytes. The per-channel trim and power registers share one small address window. The index register decides which channel that window reaches, and only one channel can be reached at a time.

A calibration engine, also outside this block, delivers trim results on a load port. Each load sets both the live trim values and a saved copy of them, and a soft reset restores the trims from that copy. The power-mode register is the one writable register that a soft reset leaves alone. Each channel drives its own power-mode output. A channel whose mode register is zero follows the shared three-state power pin. Any other value gives that channel its own register setting.

A burst begins with a start pulse that captures the address port. From then on, each read or write goes to an internal pointer, which steps up by one after each access. The burst ends after the access whose address equals the burst-end register.

Top module: `cfg_regbank`

## Requirements
- R1: After a hard reset the index register (0x10) and the burst-end register (0x02) read 0x00, and every channel's power output follows the pin.
- R2: The index register at 0x10 reads back the byte last written to it. It selects channel n only when bit n is the only bit set and n < NCH. Any other value, including 0x00, several set bits, or a bit at or above NCH, selects no channel.
- R3: While no channel is selected, a read of any address from 0x20 to 0x25 returns 0xAD, and a write to those addresses changes no channel's registers.
- R4: With channel n selected, 0x20 (coarse offset, 8 bits), 0x21 (fine offset, 8 bits), 0x22 (coarse gain, 4 bits in [3:0], reads [7:4] as zero), 0x23 (medium gain, 8 bits) and 0x24 (fine gain, 8 bits) read and write channel n only. Hard reset values are 0x80 for the 8-bit trims and 0x0 for coarse gain.
- R5: A one-cycle pulse on cal_load writes the five cal_* values into the live trims of channel cal_ch and into that channel's saved copy.
- R6: With channel n selected, 0x25 holds a 3-bit power code in [2:0] for channel n alone. Code 001 gives normal, 010 gives nap and 100 gives sleep, and every other nonzero code gives normal. On pwr_mode[2n+1:2n] the output encoding is 00 normal, 01 nap and 10 sleep.
- R7: A channel whose power code is 000 follows pin_mode. Pin value 00 gives normal, 01 nap and 10 sleep, and 11 gives normal. Every channel in this state follows the pin at the same time.
- R8: Writing a byte with bit 0 set to address 0x00 is a soft reset. It clears the index and burst-end registers, ends any burst, and restores every channel's trims from its saved copy (0x80/0x0 if nothing was ever loaded). The power codes keep their values.
- R9: Address 0x08 reads CHIP_ID and 0x09 reads CHIP_VER. Writes to either address leave the read value unchanged.
- R10: A burst_go pulse captures addr as the burst pointer and raises burst_busy. While busy, each access uses the pointer instead of addr, and the pointer then steps up by one. burst_busy drops after the access made at the address equal to the burst-end register.
- R11: Read data appears on rdata in the cycle after rd_en. Addresses that map to no register read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hard reset |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| rdata | output | 8 | Registered read data |
| burst_go | input | 1 | Starts a burst at addr |
| burst_busy | output | 1 | A burst is in progress |
| cal_load | input | 1 | Calibration result strobe |
| cal_ch | input | CHW | Channel the calibration result belongs to |
| cal_offc | input | 8 | Calibrated coarse offset |
| cal_offf | input | 8 | Calibrated fine offset |
| cal_gc | input | 4 | Calibrated coarse gain |
| cal_gm | input | 8 | Calibrated medium gain |
| cal_gf | input | 8 | Calibrated fine gain |
| pin_mode | input | 2 | Three-state power pin: 00 normal, 01 nap, 10 sleep |
| pwr_mode | output | 2*NCH | Per-channel power mode, 2 bits per channel |

## Verification
A wrong index decode shows up on the first read of the indexed window: the read returns 0xAD where trim data was expected, or returns data where 0xAD was expected, one clock after the read strobe. A corrupt power code or a wrong pin merge shows up on pwr_mode at once, because the output is combinational from the stored code and the pin. A corrupt saved trim stays hidden until a soft reset. A burst pointer that skips or stops at the wrong address shows up as burst_busy falling on the wrong access, and as trim values landing one register off on the next direct read.

// File: rtl/cfg_regbank_pkg.sv
// Package: shared address map, types and decode functions for the
// channel-indexed configuration register bank.
// Assumes 8-bit addresses and data.
package cfg_regbank_pkg;

    localparam logic [7:0] A_CTRL  = 8'h00;
    localparam logic [7:0] A_BEND  = 8'h02;
    localparam logic [7:0] A_ID    = 8'h08;
    localparam logic [7:0] A_VER   = 8'h09;
    localparam logic [7:0] A_IDX   = 8'h10;
    localparam logic [7:0] A_OFFC  = 8'h20;
    localparam logic [7:0] A_OFFF  = 8'h21;
    localparam logic [7:0] A_GC    = 8'h22;
    localparam logic [7:0] A_GM    = 8'h23;
    localparam logic [7:0] A_GF    = 8'h24;
    localparam logic [7:0] A_PMODE = 8'h25;
    localparam logic [7:0] ERR_BYTE = 8'hAD;

    typedef enum logic [1:0] {
        PM_NORMAL = 2'b00,
        PM_NAP    = 2'b01,
        PM_SLEEP  = 2'b10
    } pm_t;

    typedef struct packed {
        logic [7:0] offc;
        logic [7:0] offf;
        logic [3:0] gc;
        logic [7:0] gm;
        logic [7:0] gf;
    } trim_t;

    localparam trim_t TRIM_DEF = '{offc: 8'h80, offf: 8'h80, gc: 4'h0,
                                   gm: 8'h80, gf: 8'h80};

    // Three-state pin to power mode; the unused pin value maps to normal.
    function automatic pm_t pin_decode(input logic [1:0] p);
        case (p)
            2'b01:   return PM_NAP;
            2'b10:   return PM_SLEEP;
            default: return PM_NORMAL;
        endcase
    endfunction

    // Register power code to power mode; codes not listed map to normal.
    function automatic pm_t code_decode(input logic [2:0] c);
        case (c)
            3'b010:  return PM_NAP;
            3'b100:  return PM_SLEEP;
            default: return PM_NORMAL;
        endcase
    endfunction

    // True for addresses in the per-channel window.
    function automatic logic is_indexed(input logic [7:0] a);
        return (a >= A_OFFC) && (a <= A_PMODE);
    endfunction

endpackage

// File: rtl/cfg_index_decode.sv
// Index decode: turns the index byte into a valid flag and a channel
// number. Valid only when exactly one bit below NCH is set and no bit
// at or above NCH is set.
module cfg_index_decode #(
    parameter int NCH = 2,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [7:0]     idx,
    output logic           valid,
    output logic [CHW-1:0] ch
);
    logic [3:0] cnt;
    logic       upper;

    // Count the selecting bits and flag any bit above the channel range.
    always_comb begin
        cnt   = 4'd0;
        upper = 1'b0;
        ch    = '0;
        for (int i = 0; i < 8; i++) begin
            if (idx[i]) begin
                if (i < NCH) begin
                    cnt = cnt + 4'd1;
                    ch  = CHW'(i);
                end else begin
                    upper = 1'b1;
                end
            end
        end
        valid = !upper && (cnt == 4'd1);
    end
endmodule

// File: rtl/cfg_burst_seq.sv
// Burst sequencer: holds the auto-incrementing address pointer. A start
// pulse captures the start address. Each access during a burst advances
// the pointer, and the access made at the end address finishes the burst.
// Assumes start and access are not pulsed in the same cycle.
module cfg_burst_seq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       soft_rst,
    input  logic       go,
    input  logic [7:0] start_addr,
    input  logic [7:0] end_addr,
    input  logic       access,
    output logic       busy,
    output logic [7:0] ptr
);
    // Pointer and busy flag sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            ptr  <= 8'h00;
        end else if (soft_rst) begin
            busy <= 1'b0;
        end else if (go) begin
            busy <= 1'b1;
            ptr  <= start_addr;
        end else if (busy && access) begin
            if (ptr == end_addr) begin
                busy <= 1'b0;
            end else begin
                ptr <= ptr + 8'd1;
            end
        end
    end
endmodule

// File: rtl/cfg_chan_regs.sv
// One channel's registers: live trims, a saved calibration copy, and the
// power code. Writes are pre-qualified by the top (channel selected,
// address in window); woff is the low three address bits (0..5).
// A soft reset restores the live trims from the saved copy and leaves
// the power code unchanged.
module cfg_chan_regs
    import cfg_regbank_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       soft_rst,
    input  logic       wr_en,
    input  logic [2:0] woff,
    input  logic [7:0] wdata,
    input  logic       cal_ld,
    input  trim_t      cal_val,
    output trim_t      trims,
    output logic [2:0] pcode
);
    trim_t saved;

    // Saved copy of the latest calibration result.
    always_ff @(posedge clk) begin
        if (!rst_n)      saved <= TRIM_DEF;
        else if (cal_ld) saved <= cal_val;
    end

    // Live trims: calibration load, then register writes override fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trims <= TRIM_DEF;
        end else if (soft_rst) begin
            trims <= saved;
        end else begin
            if (cal_ld) trims <= cal_val;
            if (wr_en) begin
                case (woff)
                    3'd0:    trims.offc <= wdata;
                    3'd1:    trims.offf <= wdata;
                    3'd2:    trims.gc   <= wdata[3:0];
                    3'd3:    trims.gm   <= wdata;
                    3'd4:    trims.gf   <= wdata;
                    default: ;
                endcase
            end
        end
    end

    // Power code: cleared only by hard reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                        pcode <= 3'b000;
        else if (wr_en && woff == 3'd5)    pcode <= wdata[2:0];
    end
endmodule

// File: rtl/cfg_pwr_merge.sv
// Power merge for one channel: code 000 hands control to the shared pin,
// any other code selects the channel's own register setting.
module cfg_pwr_merge
    import cfg_regbank_pkg::*;
(
    input  logic [1:0] pin,
    input  logic [2:0] code,
    output logic [1:0] mode
);
    // Select pin or register source.
    always_comb begin
        if (code == 3'b000) mode = pin_decode(pin);
        else                mode = code_decode(code);
    end
endmodule

// File: rtl/cfg_regbank.sv
// Top of the channel-indexed configuration register bank. Decodes
// register cycles from a serial front end, steers the per-channel window
// through the index register, sequences bursts, returns registered read
// data one cycle after the strobe, and merges the power pin with the
// per-channel power codes. Assumes one strobe per access and that
// burst_go never coincides with an access.
module cfg_regbank
    import cfg_regbank_pkg::*;
#(
    parameter int         NCH      = 2,
    parameter logic [7:0] CHIP_ID  = 8'h5A,
    parameter logic [7:0] CHIP_VER = 8'h03,
    localparam int        CHW      = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       addr,
    input  logic [7:0]       wdata,
    input  logic             wr_en,
    input  logic             rd_en,
    output logic [7:0]       rdata,
    input  logic             burst_go,
    output logic             burst_busy,
    input  logic             cal_load,
    input  logic [CHW-1:0]   cal_ch,
    input  logic [7:0]       cal_offc,
    input  logic [7:0]       cal_offf,
    input  logic [3:0]       cal_gc,
    input  logic [7:0]       cal_gm,
    input  logic [7:0]       cal_gf,
    input  logic [1:0]       pin_mode,
    output logic [2*NCH-1:0] pwr_mode
);
    logic [7:0]     burst_ptr;
    logic [7:0]     eff_addr;
    logic [7:0]     idx_q;
    logic [7:0]     burst_end_q;
    logic           idx_valid;
    logic [CHW-1:0] idx_ch;
    logic           soft_rst;
    logic           win_wr;
    logic [7:0]     rd_val;
    trim_t          cal_val;
    trim_t          trims_a [NCH];
    logic [2:0]     pcode_a [NCH];

    assign eff_addr = burst_busy ? burst_ptr : addr;
    assign soft_rst = wr_en && (eff_addr == A_CTRL) && wdata[0];
    assign win_wr   = wr_en && is_indexed(eff_addr) && idx_valid;
    assign cal_val  = '{offc: cal_offc, offf: cal_offf, gc: cal_gc,
                        gm: cal_gm, gf: cal_gf};

    cfg_burst_seq u_burst (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .go(burst_go),
        .start_addr(addr), .end_addr(burst_end_q),
        .access(wr_en || rd_en), .busy(burst_busy), .ptr(burst_ptr)
    );

    cfg_index_decode #(.NCH(NCH)) u_idx (
        .idx(idx_q), .valid(idx_valid), .ch(idx_ch)
    );

    // Index register: cleared by both resets.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)                    idx_q <= 8'h00;
        else if (wr_en && eff_addr == A_IDX)       idx_q <= wdata;
    end

    // Burst-end register: cleared by both resets.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)                    burst_end_q <= 8'h00;
        else if (wr_en && eff_addr == A_BEND)      burst_end_q <= wdata;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic sel;
        assign sel = (idx_ch == CHW'(g));

        cfg_chan_regs u_regs (
            .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
            .wr_en(win_wr && sel), .woff(eff_addr[2:0]), .wdata(wdata),
            .cal_ld(cal_load && cal_ch == CHW'(g)), .cal_val(cal_val),
            .trims(trims_a[g]), .pcode(pcode_a[g])
        );

        cfg_pwr_merge u_pwr (
            .pin(pin_mode), .code(pcode_a[g]), .mode(pwr_mode[2*g +: 2])
        );
    end

    // Read mux over shared and indexed registers.
    always_comb begin
        rd_val = 8'h00;
        if (is_indexed(eff_addr)) begin
            if (!idx_valid) begin
                rd_val = ERR_BYTE;
            end else begin
                case (eff_addr)
                    A_OFFC:  rd_val = trims_a[idx_ch].offc;
                    A_OFFF:  rd_val = trims_a[idx_ch].offf;
                    A_GC:    rd_val = {4'h0, trims_a[idx_ch].gc};
                    A_GM:    rd_val = trims_a[idx_ch].gm;
                    A_GF:    rd_val = trims_a[idx_ch].gf;
                    default: rd_val = {5'b0, pcode_a[idx_ch]};
                endcase
            end
        end else begin
            case (eff_addr)
                A_BEND:  rd_val = burst_end_q;
                A_ID:    rd_val = CHIP_ID;
                A_VER:   rd_val = CHIP_VER;
                A_IDX:   rd_val = idx_q;
                default: rd_val = 8'h00;
            endcase
        end
    end

    // Registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= 8'h00;
        else if (rd_en) rdata <= rd_val;
    end
endmodule

// File: rtl/cfg_regbank_chk.sv
// Checker for cfg_regbank: temporal properties over the ports and the
// internal signals that link the decode, burst and read paths.
module cfg_regbank_chk #(
    parameter int         NCH     = 2,
    parameter logic [7:0] CHIP_ID = 8'h5A
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_en,
    input logic [7:0]       eff_addr,
    input logic             idx_valid,
    input logic [7:0]       rdata,
    input logic             soft_rst,
    input logic [1:0]       pin_mode,
    input logic [2*NCH-1:0] pwr_mode,
    input logic             burst_busy,
    input logic [7:0]       burst_ptr,
    input logic [7:0]       burst_end_q
);
    // R3
    err_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && eff_addr >= 8'h20 && eff_addr <= 8'h25 && !idx_valid)
        |=> (rdata == 8'hAD));

    // R9
    chip_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && eff_addr == 8'h08) |=> (rdata == CHIP_ID));

    // R8
    soft_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!$stable(pin_mode) || $stable(pwr_mode)));

    // R10
    burst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(burst_busy) && !$past(soft_rst))
        |-> ($past(burst_ptr) == $past(burst_end_q)));

    for (genvar g = 0; g < NCH; g++) begin : g_pm
        // R6
        pm_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pwr_mode[2*g +: 2] != 2'b11);
    end
endmodule

bind cfg_regbank cfg_regbank_chk #(.NCH(NCH), .CHIP_ID(CHIP_ID)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .eff_addr(eff_addr),
    .idx_valid(idx_valid), .rdata(rdata), .soft_rst(soft_rst),
    .pin_mode(pin_mode), .pwr_mode(pwr_mode), .burst_busy(burst_busy),
    .burst_ptr(burst_ptr), .burst_end_q(burst_end_q)
);

// File: tb/cfg_regbank_bench.sv
// Directed bench for cfg_regbank: one task per scenario, each checking
// its own results. Inputs change on the falling edge and outputs are
// sampled on the falling edge.
module cfg_regbank_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 2;
    localparam logic [7:0] ID  = 8'h5A;
    localparam logic [7:0] VER = 8'h03;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [7:0]      addr, wdata, rdata;
    logic            wr_en, rd_en, burst_go, burst_busy, cal_load;
    logic [0:0]      cal_ch;
    logic [7:0]      cal_offc, cal_offf, cal_gm, cal_gf;
    logic [3:0]      cal_gc;
    logic [1:0]      pin_mode;
    logic [2*NCH-1:0] pwr_mode;

    int n_chk = 0;
    int n_fail = 0;

    cfg_regbank #(.NCH(NCH), .CHIP_ID(ID), .CHIP_VER(VER)) u_cfg_regbank (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata),
        .burst_go(burst_go), .burst_busy(burst_busy),
        .cal_load(cal_load), .cal_ch(cal_ch), .cal_offc(cal_offc),
        .cal_offf(cal_offf), .cal_gc(cal_gc), .cal_gm(cal_gm),
        .cal_gf(cal_gf), .pin_mode(pin_mode), .pwr_mode(pwr_mode)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        check(tag, v, exp);
    endtask

    function automatic logic [7:0] pm(input int ch);
        return {6'b0, pwr_mode[2*ch +: 2]};
    endfunction

    task automatic t_reset();
        check("R1 pwr ch0", pm(0), 8'h00);
        check("R1 pwr ch1", pm(1), 8'h00);
        rd_chk("R1 index", 8'h10, 8'h00);
        rd_chk("R1 burst end", 8'h02, 8'h00);
        rd_chk("R3 err at reset", 8'h20, 8'hAD);
        rd_chk("R11 unmapped", 8'h40, 8'h00);
    endtask

    task automatic t_index();
        wr(8'h10, 8'h03);
        rd_chk("R2 index readback", 8'h10, 8'h03);
        rd_chk("R2 two bits invalid", 8'h21, 8'hAD);
        wr(8'h10, 8'h04);
        rd_chk("R2 bit above NCH invalid", 8'h25, 8'hAD);
        wr(8'h20, 8'h11);
        wr(8'h10, 8'h01);
        rd_chk("R3 write ignored ch0", 8'h20, 8'h80);
        wr(8'h10, 8'h02);
        rd_chk("R3 write ignored ch1", 8'h20, 8'h80);
    endtask

    task automatic t_trim();
        wr(8'h10, 8'h01);
        wr(8'h20, 8'h12); wr(8'h21, 8'h34); wr(8'h22, 8'hFF);
        wr(8'h23, 8'h56); wr(8'h24, 8'h78);
        wr(8'h10, 8'h02);
        rd_chk("R4 ch1 default gc", 8'h22, 8'h00);
        wr(8'h20, 8'h9A);
        rd_chk("R4 ch1 offc", 8'h20, 8'h9A);
        rd_chk("R4 ch1 offf untouched", 8'h21, 8'h80);
        wr(8'h10, 8'h01);
        rd_chk("R4 ch0 offc", 8'h20, 8'h12);
        rd_chk("R4 ch0 offf", 8'h21, 8'h34);
        rd_chk("R4 ch0 gc 4 bits", 8'h22, 8'h0F);
        rd_chk("R4 ch0 gm", 8'h23, 8'h56);
        rd_chk("R4 ch0 gf", 8'h24, 8'h78);
    endtask

    task automatic t_cal();
        cal_ch = 1'b1; cal_offc = 8'hA1; cal_offf = 8'hB2; cal_gc = 4'hC;
        cal_gm = 8'hD3; cal_gf = 8'hE4; cal_load = 1'b1;
        @(negedge clk);
        cal_load = 1'b0;
        wr(8'h10, 8'h02);
        rd_chk("R5 cal offc", 8'h20, 8'hA1);
        rd_chk("R5 cal gc", 8'h22, 8'h0C);
        rd_chk("R5 cal gf", 8'h24, 8'hE4);
        wr(8'h10, 8'h01);
        rd_chk("R5 other channel kept", 8'h20, 8'h12);
    endtask

    task automatic t_soft();
        wr(8'h10, 8'h01); wr(8'h25, 8'h02);
        wr(8'h10, 8'h02); wr(8'h20, 8'h55);
        wr(8'h02, 8'h24);
        wr(8'h00, 8'h01);
        rd_chk("R8 index cleared", 8'h10, 8'h00);
        rd_chk("R8 burst end cleared", 8'h02, 8'h00);
        check("R8 ch0 nap kept", pm(0), 8'h01);
        wr(8'h10, 8'h01);
        rd_chk("R8 ch0 offc default", 8'h20, 8'h80);
        rd_chk("R8 ch0 code kept", 8'h25, 8'h02);
        wr(8'h10, 8'h02);
        rd_chk("R8 ch1 offc from cal", 8'h20, 8'hA1);
        rd_chk("R8 ch1 gm from cal", 8'h23, 8'hD3);
    endtask

    task automatic t_pwr();
        pin_mode = 2'b01; #1;
        check("R7 pin nap ch1", pm(1), 8'h01);
        check("R6 ch0 reg nap", pm(0), 8'h01);
        @(negedge clk);
        pin_mode = 2'b10; #1;
        check("R7 pin sleep ch1", pm(1), 8'h02);
        check("R6 ch0 unaffected by pin", pm(0), 8'h01);
        @(negedge clk);
        pin_mode = 2'b11; #1;
        check("R7 pin illegal", pm(1), 8'h00);
        @(negedge clk);
        pin_mode = 2'b00;
        wr(8'h10, 8'h02);
        wr(8'h25, 8'h04); check("R6 code sleep", pm(1), 8'h02);
        wr(8'h25, 8'h01); check("R6 code normal", pm(1), 8'h00);
        wr(8'h25, 8'h02); check("R6 code nap", pm(1), 8'h01);
        wr(8'h25, 8'h03); check("R6 code 011", pm(1), 8'h00);
        wr(8'h25, 8'h07); check("R6 code 111", pm(1), 8'h00);
        wr(8'h10, 8'h01); wr(8'h25, 8'h00);
        wr(8'h10, 8'h02); wr(8'h25, 8'h00);
        pin_mode = 2'b10; #1;
        check("R7 all follow ch0", pm(0), 8'h02);
        check("R7 all follow ch1", pm(1), 8'h02);
        @(negedge clk);
        pin_mode = 2'b00;
    endtask

    task automatic t_chipid();
        rd_chk("R9 id", 8'h08, ID);
        rd_chk("R9 version", 8'h09, VER);
        wr(8'h08, 8'hFF); wr(8'h09, 8'hFF);
        rd_chk("R9 id after write", 8'h08, ID);
        rd_chk("R9 version after write", 8'h09, VER);
    endtask

    task automatic t_burst();
        logic [7:0] v;
        wr(8'h10, 8'h01);
        wr(8'h02, 8'h22);
        addr = 8'h20; burst_go = 1'b1;
        @(negedge clk);
        burst_go = 1'b0;
        check("R10 busy after go", {7'b0, burst_busy}, 8'h01);
        wr(8'h40, 8'h11);
        wr(8'h40, 8'h22);
        check("R10 busy before end", {7'b0, burst_busy}, 8'h01);
        wr(8'h40, 8'h33);
        check("R10 idle after end", {7'b0, burst_busy}, 8'h00);
        rd_chk("R10 burst wr offc", 8'h20, 8'h11);
        rd_chk("R10 burst wr offf", 8'h21, 8'h22);
        rd_chk("R10 burst wr gc", 8'h22, 8'h03);
        rd_chk("R10 gm untouched", 8'h23, 8'h80);
        addr = 8'h21; burst_go = 1'b1;
        @(negedge clk);
        burst_go = 1'b0;
        rd(8'h00, v); check("R10 burst rd 1", v, 8'h22);
        rd(8'h00, v); check("R10 burst rd 2", v, 8'h03);
        check("R10 idle after read burst", {7'b0, burst_busy}, 8'h00);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; addr = 8'h00; wdata = 8'h00; wr_en = 1'b0;
        rd_en = 1'b0; burst_go = 1'b0; cal_load = 1'b0; cal_ch = 1'b0;
        cal_offc = 8'h00; cal_offf = 8'h00; cal_gc = 4'h0;
        cal_gm = 8'h00; cal_gf = 8'h00; pin_mode = 2'b00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_index();
        t_trim();
        t_cal();
        t_soft();
        t_pwr();
        t_chipid();
        t_burst();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule